// File: doc/BRIEF.md
# Addressed Serial I/O Slave with Parity and Access Watchdog

This block is one slave on a multiplexer bus that many boards share in a daisy chain. The host talks to it over three wires: a serial clock, a data line and a frame strobe. The slave also drives one data-return line back to the host. The slave owns two 32-bit ports. It returns the input port as a whole word, and it holds the output port in a latch that only a parity-clean write may change. A 5-bit board switch places the slave at one eight-byte slot of a 256-byte address space, so up to 32 slaves can share the bus.

Each frame carries an address byte and then a 36-bit data phase: 32 data bits and one even-parity bit per byte. For a read, the slave captures the input word when the address is decoded and shifts it out with parity it generates itself. For a write, the slave checks the received parity. A mismatch leaves the latch untouched and raises an error flag for the host. Each 8-bit group of output lines has its own polarity, either sourcing or sinking.

When its strap allows, an access watchdog turns every output driver off if the host has not addressed the board for a set time. Any later access to the board restores the latched outputs.

Top module: `rio_slave`

## Requirements
- R1: The board index is the bitwise inverse of `brd_sw`. Bit 0 is switch 1, and an open switch (value 0) contributes a 1. The base address is index×8. A read frame addresses the base, and a write frame addresses base+4. Any other address produces no return drive, no latch change and no watchdog re-arm.
- R2: A frame is the span while `bus_strobe` is high. Bits are taken on rising edges of `bus_sclk`. The 8 address bits come first, LSB first. Then 32 data bits come LSB first, then 4 parity bits for bytes 0 to 3 in that order. Each parity bit is the XOR of its byte, so each byte plus its bit has an even count of ones.
- R3: On a read, the input word is captured when the address is decoded. Later changes to `in_word` do not affect the frame. Bit k of the 36-bit data phase is driven on `bus_sdo` before the k-th data rising edge.
- R4: `bus_sdo_en` is high only during the data phase of a read addressed to this board. It first rises in the clock cycle after the address-completing edge.
- R5: A write whose 4 parity bits all match updates the output latch and clears `perr`.
- R6: A write with any parity mismatch leaves the latch unchanged and sets `perr`. `perr` stays set until the next clean write.
- R7: The output line is set per group g. With `grp_sink[g]=0` (sourcing), the line equals the latch bit. With `grp_sink[g]=1` (sinking), the line is the inverse of the latch bit, because an on bit pulls the line low.
- R8: While `wd_dis` is 1, the watchdog never trips.
- R9: While `wd_dis` is 0, the watchdog trips WD_CYCLES clock cycles after the last access or after the enable. A trip turns all drivers off: sourcing lines go to 0 and sinking lines go to 1.
- R10: A read or a write addressed to this board re-arms a tripped watchdog, even a write with bad parity. The outputs then show the retained latch value again.
- R11: Reset clears the latch and `perr`, clears the watchdog, and leaves `bus_sdo_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brd_sw | input | 5 | Board switch, 1 = closed |
| wd_dis | input | 1 | Watchdog disable strap, 1 = disabled |
| grp_sink | input | 4 | Per-group output polarity, 1 = sinking |
| bus_sclk | input | 1 | Bus serial clock |
| bus_strobe | input | 1 | Frame strobe |
| bus_sdi | input | 1 | Serial data from host |
| bus_sdo | output | 1 | Serial data to host |
| bus_sdo_en | output | 1 | Drive enable for `bus_sdo` |
| in_word | input | 32 | Input port |
| out_lines | output | 32 | Output line levels |
| perr | output | 1 | Last write failed parity |

## Verification
The bench builds the slave with WD_CYCLES = 400 instead of the 1.5 s default. At that value, the full sequence fits in a few thousand cycles: the counter starts at the enable, the bench checks that nothing has tripped at 300 cycles, sees the trip at 450 cycles, and then re-arms the watchdog with a read frame. The board switch is set to index 1, so the base address is 8. The bench then moves the switch to index 0 to show the address tracking it. Mixed group polarity (0101, then 1010) makes the sourcing and the sinking off-levels differ within one word.

// File: rtl/rio_pkg.sv
package rio_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int GRP_W  = 8;
    localparam int N_GRP  = DATA_W / GRP_W;
    localparam int FRAME_W = DATA_W + N_GRP;
    localparam int SW_W   = 5;
    localparam int CNT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    typedef struct packed {
        logic [N_GRP-1:0]  par;
        logic [DATA_W-1:0] word;
    } frame_t;

    function automatic logic [N_GRP-1:0] grp_parity(input logic [DATA_W-1:0] w);
        logic [N_GRP-1:0] p;
        for (int g = 0; g < N_GRP; g++) p[g] = ^w[g*GRP_W +: GRP_W];
        return p;
    endfunction

    function automatic logic [ADDR_W-1:0] board_base(input logic [SW_W-1:0] sw);
        return {~sw, 3'b000};
    endfunction
endpackage

// File: rtl/rio_addr_match.sv
module rio_addr_match
    import rio_pkg::*;
(
    input  logic [SW_W-1:0]   brd_sw,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_rd,
    output logic              hit_wr
);
    logic [ADDR_W-1:0] base;
    always_comb begin
        base   = board_base(brd_sw);
        hit_rd = (addr == base);
        hit_wr = (addr == (base | ADDR_W'(4)));
    end
endmodule

// File: rtl/rio_frame.sv
module rio_frame
    import rio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   brd_sw,
    input  logic              sclk,
    input  logic              strobe,
    input  logic              sdi,
    input  logic [DATA_W-1:0] in_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              kick,
    output logic [DATA_W-1:0] latch,
    output logic              perr
);
    logic              sclk_q;
    logic              rise;
    phase_t            ph;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_sr, addr_nx;
    frame_t            sr, frame_nx;
    logic              hit_rd, hit_wr;
    logic              wr_done, par_ok;

    assign rise     = sclk & ~sclk_q;
    assign addr_nx  = {sdi, addr_sr[ADDR_W-1:1]};
    assign frame_nx = {sdi, sr[FRAME_W-1:1]};
    assign par_ok   = (grp_parity(frame_nx.word) == frame_nx.par);

    rio_addr_match u_match (
        .brd_sw (brd_sw),
        .addr   (addr_nx),
        .hit_rd (hit_rd),
        .hit_wr (hit_wr)
    );

    always_comb begin
        kick    = strobe && rise && (ph == PH_ADDR) &&
                  (cnt == CNT_W'(ADDR_W-1)) && (hit_rd || hit_wr);
        wr_done = strobe && rise && (ph == PH_WR) && (cnt == CNT_W'(FRAME_W-1));
        sdo_en  = (ph == PH_RD);
        sdo     = sdo_en ? sr[0] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            ph      <= PH_ADDR;
            cnt     <= '0;
            addr_sr <= '0;
            sr      <= '0;
            latch   <= '0;
            perr    <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (!strobe) begin
                ph  <= PH_ADDR;
                cnt <= '0;
            end else if (rise) begin
                case (ph)
                    PH_ADDR: begin
                        addr_sr <= addr_nx;
                        if (cnt == CNT_W'(ADDR_W-1)) begin
                            cnt <= '0;
                            if (hit_rd) begin
                                ph <= PH_RD;
                                sr <= {grp_parity(in_word), in_word};
                            end else if (hit_wr) begin
                                ph <= PH_WR;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_RD: begin
                        sr  <= sr >> 1;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(FRAME_W-1)) ph <= PH_SKIP;
                    end
                    PH_WR: begin
                        sr  <= frame_nx;
                        cnt <= cnt + 1'b1;
                        if (wr_done) begin
                            ph <= PH_SKIP;
                            if (par_ok) begin
                                latch <= frame_nx.word;
                                perr  <= 1'b0;
                            end else begin
                                perr  <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    sdo_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> $past(rise));
    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !par_ok) |=> $stable(latch));
    // R5
    perr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_done |=> $stable(perr));
endmodule

// File: rtl/rio_watchdog.sv
module rio_watchdog #(
    parameter int WD_CYCLES = 375_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_dis,
    input  logic kick,
    output logic tripped
);
    localparam int CW = $clog2(WD_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || wd_dis || kick) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (!tripped) begin
            if (cnt == CW'(WD_CYCLES - 1)) tripped <= 1'b1;
            else                           cnt     <= cnt + 1'b1;
        end
    end

    // R8
    wd_off_chk: assert property (@(posedge clk) disable iff (rst)
        wd_dis |=> !tripped);
    // R10
    wd_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !tripped);
    // R9
    wd_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(WD_CYCLES));
endmodule

// File: rtl/rio_out_stage.sv
module rio_out_stage
    import rio_pkg::*;
(
    input  logic [DATA_W-1:0] latch,
    input  logic [N_GRP-1:0]  sink,
    input  logic              blank,
    output logic [DATA_W-1:0] lines
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [GRP_W-1:0] on;
        assign on = blank ? '0 : latch[g*GRP_W +: GRP_W];
        assign lines[g*GRP_W +: GRP_W] = sink[g] ? ~on : on;
    end
endmodule

// File: rtl/rio_slave.sv
module rio_slave
    import rio_pkg::*;
#(
    parameter int WD_CYCLES = 375_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   brd_sw,
    input  logic              wd_dis,
    input  logic [N_GRP-1:0]  grp_sink,
    input  logic              bus_sclk,
    input  logic              bus_strobe,
    input  logic              bus_sdi,
    output logic              bus_sdo,
    output logic              bus_sdo_en,
    input  logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_lines,
    output logic              perr
);
    logic              kick;
    logic              tripped;
    logic [DATA_W-1:0] latch;

    rio_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .brd_sw  (brd_sw),
        .sclk    (bus_sclk),
        .strobe  (bus_strobe),
        .sdi     (bus_sdi),
        .in_word (in_word),
        .sdo     (bus_sdo),
        .sdo_en  (bus_sdo_en),
        .kick    (kick),
        .latch   (latch),
        .perr    (perr)
    );

    rio_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .wd_dis  (wd_dis),
        .kick    (kick),
        .tripped (tripped)
    );

    rio_out_stage u_out (
        .latch (latch),
        .sink  (grp_sink),
        .blank (tripped),
        .lines (out_lines)
    );

    // R11
    sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_sdo_en);
endmodule

// File: tb/rio_slave_tb.sv
module rio_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  brd_sw = 5'b11110;
    logic        wd_dis = 1'b1;
    logic [3:0]  grp_sink = 4'b0101;
    logic        bus_sclk = 1'b0, bus_strobe = 1'b0, bus_sdi = 1'b0;
    logic        bus_sdo, bus_sdo_en;
    logic [31:0] in_word = '0;
    logic [31:0] out_lines;
    logic        perr;

    int tests = 0, fails = 0;
    logic [31:0] written = '0;

    always #2 clk = ~clk;

    rio_slave #(.WD_CYCLES(400)) dut_i (
        .clk(clk), .rst(rst), .brd_sw(brd_sw), .wd_dis(wd_dis),
        .grp_sink(grp_sink), .bus_sclk(bus_sclk), .bus_strobe(bus_strobe),
        .bus_sdi(bus_sdi), .bus_sdo(bus_sdo), .bus_sdo_en(bus_sdo_en),
        .in_word(in_word), .out_lines(out_lines), .perr(perr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] par_of(input logic [31:0] w);
        logic [3:0] p = '0;
        for (int b = 0; b < 32; b++) p[b/8] = p[b/8] ^ w[b];
        return p;
    endfunction

    function automatic logic [31:0] lines_of(input logic [31:0] w, input logic [3:0] s, input bit off);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) begin
            r[b] = off ? 1'b0 : w[b];
            if (s[b/8]) r[b] = ~r[b];
        end
        return r;
    endfunction

    task automatic xfer(input logic [7:0] addr, input logic [35:0] wbits,
                        input bit swap_in, input logic [31:0] new_in,
                        output logic [35:0] rbits, output bit saw_en);
        rbits = '0; saw_en = 0;
        bus_strobe = 1'b1; tick(2);
        for (int i = 0; i < 44; i++) begin
            bus_sclk = 1'b0;
            bus_sdi  = (i < 8) ? addr[i] : wbits[i-8];
            if (swap_in && i == 10) in_word = new_in;
            tick(3);
            if (i >= 8) begin
                rbits[i-8] = bus_sdo;
                if (bus_sdo_en) saw_en = 1;
            end
            bus_sclk = 1'b1; tick(3);
        end
        bus_sclk = 1'b0; tick(2);
        bus_strobe = 1'b0; bus_sdi = 1'b0; tick(3);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] w, input logic [3:0] pflip);
        logic [35:0] r; bit e;
        xfer(addr, {par_of(w) ^ pflip, w}, 0, '0, r, e);
    endtask

    task automatic t_reset();
        chk("R11 lines", {4'b0, out_lines}, {4'b0, lines_of(32'h0, grp_sink, 0)});
        chk("R11 perr", {35'b0, perr}, 36'd0);
        chk("R11 sdo_en", {35'b0, bus_sdo_en}, 36'd0);
    endtask

    task automatic t_write_ok();
        written = 32'hA5C3_3C96;
        wr(8'd12, written, 4'h0);
        chk("R5 R2 lines", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        chk("R5 perr", {35'b0, perr}, 36'd0);
    endtask

    task automatic t_polarity();
        grp_sink = 4'b1010; tick(1);
        chk("R7 sink 1010", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        grp_sink = 4'b0101; tick(1);
        chk("R7 sink 0101", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
    endtask

    task automatic t_read();
        logic [35:0] r; bit e;
        in_word = 32'h1234_F00D;
        xfer(8'd8, '0, 1, 32'hFFFF_0000, r, e);
        chk("R3 R2 read word+parity", r, {par_of(32'h1234_F00D), 32'h1234_F00D});
        chk("R4 sdo_en seen", {35'b0, e}, 36'd1);
        in_word = 32'h8000_0001;
        xfer(8'd8, '0, 0, '0, r, e);
        chk("R3 second read", r, {par_of(32'h8000_0001), 32'h8000_0001});
    endtask

    task automatic t_bad_parity();
        wr(8'd12, 32'h0F0F_1234, 4'b0100);
        chk("R6 latch kept", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        chk("R6 perr set", {35'b0, perr}, 36'd1);
        written = 32'h0F0F_1234;
        wr(8'd12, written, 4'h0);
        chk("R5 perr cleared", {35'b0, perr}, 36'd0);
        chk("R5 lines new", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
    endtask

    task automatic t_other_addr();
        logic [35:0] r; bit e;
        wr(8'd13, 32'hDEAD_BEEF, 4'h0);
        wr(8'd4, 32'hDEAD_BEEF, 4'h0);
        chk("R1 foreign writes ignored", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        xfer(8'd9, '0, 0, '0, r, e);
        chk("R1 foreign read no drive", {35'b0, e}, 36'd0);
        brd_sw = 5'b11111;
        written = 32'h0000_00FF;
        wr(8'd4, written, 4'h0);
        chk("R1 base 0 write", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        brd_sw = 5'b11110;
    endtask

    task automatic t_wd();
        tick(1000);
        chk("R8 disabled no trip", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        wd_dis = 1'b0;
        tick(300);
        chk("R9 before limit", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        tick(150);
        chk("R9 tripped off", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 1)});
        wr(8'd20, 32'h1, 4'h0);
        chk("R1 foreign no rearm", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 1)});
        wr(8'd12, 32'h5555_5555, 4'b0001);
        chk("R10 rearm by bad write", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
        tick(500);
        chk("R9 trips again", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 1)});
        begin
            logic [35:0] r; bit e;
            xfer(8'd8, '0, 0, '0, r, e);
        end
        chk("R10 rearm by read", {4'b0, out_lines}, {4'b0, lines_of(written, grp_sink, 0)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset();
        t_write_ok();
        t_polarity();
        t_read();
        t_bad_parity();
        t_other_addr();
        t_wd();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule